// File: doc/BRIEF.md
# All-Frame Mode Tracker

This block decides whether a paging-protocol receiver has to keep decoding every frame. It keeps seventeen saturating 7-bit counters. One is a general all-frame counter, which goes up each time the vector decoder reports a message vector of the alphanumeric, hex/binary or secure kind. The other sixteen are per-temporary-address enable counters, which go up on a strobe from the address-matching logic. A temporary address stays enabled while its counter is nonzero.

The host lowers these counters by writing a 32-bit control word, handed over in parallel with a one-cycle valid strobe. The top byte is an identifier. One bit lowers the all-frame counter. Another bit holds the receiver in all-frame mode whatever the counters say. The low sixteen bits are a mask that picks which enable counters to lower. The block drives a registered all-frame-mode flag and a registered 16-bit enable vector. The receiver uses them to gate its frame decoding and address matching.

Top module: `afm_tracker`

## Requirements
- R1: When `vec_valid_i` is high and `vec_type_i` is 2'b01 (alphanumeric), 2'b10 (hex/binary) or 2'b11 (secure), the all-frame counter increases by one. When `vec_type_i` is 2'b00 (other kind), the strobe has no effect.
- R2: Every counter saturates. Further increments at 127 leave it at 127 and further decrements at 0 leave it at 0, so no counter ever wraps around.
- R3: The synchronous reset `rst` and the `dec_off_i` input both clear all seventeen counters and the force flag to zero. `dec_off_i` takes priority over any increment or decrement in the same cycle.
- R4: A control word is acted on only when `pkt_valid_i` is high and bits 31:24 equal 8'h03. A word with any other identifier changes no counter and no flag.
- R5: In an accepted control word, bit 23 set lowers the all-frame counter by one. Bit 23 clear leaves that counter as it is.
- R6: Bit 22 of an accepted control word is stored as the force flag. While it is set, `afm_o` is high. Each accepted word overwrites the flag, and bits 21:16 are ignored.
- R7: In an accepted control word, each set bit i of bits 15:0 lowers enable counter i by one. Each clear bit leaves its counter unchanged.
- R8: Bit i of `ta_inc_i` raises enable counter i by one. When an increment and a decrement reach the same counter in the same cycle, they cancel; this applies both to an enable counter and to the all-frame counter.
- R9: `ta_en_o[i]` is high exactly when enable counter i is nonzero.
- R10: `afm_o` is high exactly when the force flag is set, or the all-frame counter is nonzero, or any enable counter is nonzero.
- R11: An input sampled at clock edge k changes the counters at edge k. The outputs show the change after edge k+1 and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_off_i | input | 1 | Receiver switched off; clears all state |
| vec_valid_i | input | 1 | A message vector was decoded this cycle |
| vec_type_i | input | 2 | Vector kind: 00 other, 01 alphanumeric, 10 hex/binary, 11 secure |
| pkt_valid_i | input | 1 | Host control word valid strobe |
| pkt_data_i | input | 32 | Host control word |
| ta_inc_i | input | 16 | Per-address enable counter increment strobes |
| afm_o | output | 1 | All-frame mode required |
| ta_en_o | output | 16 | Temporary address enable vector |

## Verification
The bench drives each counter past 127 and then back below zero. A wrapping counter would show up as a mode flag or enable bit that clears after only two or three decrements, or one that sets again after an extra decrement at zero. It sweeps all 255 wrong identifiers using a word with every action bit set, so a decoder that ignores the identifier would clear enable bits or raise the force flag. It also applies an increment and a decrement to the same counter in the same cycle, turns the receiver off while an increment is pending, and samples the outputs one edge after a stimulus. A design that let the increment or decrement win, ignored the off priority, or skipped the output register would differ at those points.

// File: rtl/afm_pkg.sv
package afm_pkg;

  localparam int WORD_W  = 32;
  localparam int MASK_W  = 16;
  localparam int ID_LSB  = 24;
  localparam int DAF_BIT = 23;
  localparam int FAF_BIT = 22;
  localparam logic [7:0] CTRL_ID = 8'h03;

  typedef enum logic [1:0] {
    VEC_OTHER  = 2'b00,
    VEC_ALPHA  = 2'b01,
    VEC_HEXBIN = 2'b10,
    VEC_SECURE = 2'b11
  } vec_kind_e;

  typedef struct packed {
    logic              hit;
    logic              dec_af;
    logic              force_af;
    logic [MASK_W-1:0] dta;
  } ctrl_cmd_t;

endpackage

// File: rtl/afm_ctrl_decode.sv
module afm_ctrl_decode
  import afm_pkg::*;
(
  input  logic              pkt_valid_i,
  input  logic [WORD_W-1:0] pkt_data_i,
  output ctrl_cmd_t         cmd_o
);

  logic id_match;
  logic unused_rsvd;

  assign id_match    = (pkt_data_i[WORD_W-1:ID_LSB] == CTRL_ID);
  assign unused_rsvd = ^pkt_data_i[FAF_BIT-1:MASK_W];

  always_comb begin
    cmd_o.hit      = pkt_valid_i && id_match;
    cmd_o.dec_af   = pkt_data_i[DAF_BIT];
    cmd_o.force_af = pkt_data_i[FAF_BIT];
    cmd_o.dta      = pkt_data_i[MASK_W-1:0];
  end

endmodule

// File: rtl/afm_sat_counter.sv
module afm_sat_counter #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             up,
  input  logic             dn,
  output logic [CNT_W-1:0] cnt_o,
  output logic             nz_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_MIN = '0;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_o <= CNT_MIN;
    end else if (up && !dn && cnt_o != CNT_MAX) begin
      cnt_o <= cnt_o + 1'b1;
    end else if (dn && !up && cnt_o != CNT_MIN) begin
      cnt_o <= cnt_o - 1'b1;
    end
  end

  assign nz_o = (cnt_o != CNT_MIN);

endmodule

// File: rtl/afm_tracker.sv
module afm_tracker
  import afm_pkg::*;
#(
  parameter int NUM_TA = 16,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dec_off_i,
  input  logic              vec_valid_i,
  input  logic [1:0]        vec_type_i,
  input  logic              pkt_valid_i,
  input  logic [WORD_W-1:0] pkt_data_i,
  input  logic [NUM_TA-1:0] ta_inc_i,
  output logic              afm_o,
  output logic [NUM_TA-1:0] ta_en_o
);

  localparam int TA_BITS = NUM_TA * CNT_W;

  ctrl_cmd_t          cmd;
  logic               af_up;
  logic               af_dn;
  logic [CNT_W-1:0]   af_cnt;
  logic               af_nz;
  logic [TA_BITS-1:0] ta_cnt_flat;
  logic [NUM_TA-1:0]  ta_nz;
  logic               force_q;

  afm_ctrl_decode u_decode (
    .pkt_valid_i (pkt_valid_i),
    .pkt_data_i  (pkt_data_i),
    .cmd_o       (cmd)
  );

  assign af_up = vec_valid_i && (vec_kind_e'(vec_type_i) != VEC_OTHER);
  assign af_dn = cmd.hit && cmd.dec_af;

  afm_sat_counter #(.CNT_W(CNT_W)) u_af_cnt (
    .clk   (clk),
    .rst   (rst),
    .clr   (dec_off_i),
    .up    (af_up),
    .dn    (af_dn),
    .cnt_o (af_cnt),
    .nz_o  (af_nz)
  );

  for (genvar g = 0; g < NUM_TA; g++) begin : g_ta
    logic [CNT_W-1:0] cnt;
    logic             dn;

    assign dn = cmd.hit && cmd.dta[g];

    afm_sat_counter #(.CNT_W(CNT_W)) u_ta_cnt (
      .clk   (clk),
      .rst   (rst),
      .clr   (dec_off_i),
      .up    (ta_inc_i[g]),
      .dn    (dn),
      .cnt_o (cnt),
      .nz_o  (ta_nz[g])
    );

    assign ta_cnt_flat[g*CNT_W +: CNT_W] = cnt;
  end

  always_ff @(posedge clk) begin
    if (rst || dec_off_i) begin
      force_q <= 1'b0;
    end else if (cmd.hit) begin
      force_q <= cmd.force_af;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      afm_o   <= 1'b0;
      ta_en_o <= '0;
    end else begin
      afm_o   <= force_q || af_nz || (|ta_nz);
      ta_en_o <= ta_nz;
    end
  end

endmodule

// File: rtl/afm_tracker_chk.sv
module afm_tracker_chk #(
  parameter int NUM_TA = 16,
  parameter int CNT_W  = 7
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    dec_off_i,
  input logic                    vec_valid_i,
  input logic                    pkt_valid_i,
  input logic [7:0]              pkt_id,
  input logic                    pkt_faf,
  input logic [NUM_TA-1:0]       ta_inc_i,
  input logic [CNT_W-1:0]        af_cnt,
  input logic [NUM_TA*CNT_W-1:0] ta_cnt_flat,
  input logic                    force_q,
  input logic                    afm_o,
  input logic [NUM_TA-1:0]       ta_en_o
);

  localparam logic [CNT_W-1:0] TOP = '1;

  // R2
  af_no_wrap_up_chk: assert property (@(posedge clk) disable iff (rst)
    (af_cnt == TOP && !dec_off_i) |=> (af_cnt != '0));

  // R2
  af_no_wrap_dn_chk: assert property (@(posedge clk) disable iff (rst)
    (af_cnt == '0 && !dec_off_i) |=> (af_cnt != TOP));

  // R3
  off_clears_chk: assert property (@(posedge clk) disable iff (rst)
    dec_off_i |=> (af_cnt == '0 && ta_cnt_flat == '0 && !force_q));

  // R4
  bad_id_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid_i && pkt_id != 8'h03 && ta_inc_i == '0 && !vec_valid_i && !dec_off_i)
      |=> ($stable(af_cnt) && $stable(ta_cnt_flat) && $stable(force_q)));

  // R6
  force_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid_i && pkt_id == 8'h03 && pkt_faf && !dec_off_i) |=> ##1 afm_o);

  // R10
  af_nonzero_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (af_cnt != '0) |=> afm_o);

  // R9
  ta_zero_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    (ta_cnt_flat == '0) |=> (ta_en_o == '0));

endmodule

bind afm_tracker afm_tracker_chk #(.NUM_TA(NUM_TA), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .dec_off_i   (dec_off_i),
  .vec_valid_i (vec_valid_i),
  .pkt_valid_i (pkt_valid_i),
  .pkt_id      (pkt_data_i[31:24]),
  .pkt_faf     (pkt_data_i[22]),
  .ta_inc_i    (ta_inc_i),
  .af_cnt      (af_cnt),
  .ta_cnt_flat (ta_cnt_flat),
  .force_q     (force_q),
  .afm_o       (afm_o),
  .ta_en_o     (ta_en_o)
);

// File: tb/afm_tracker_tb.sv
module afm_tracker_tb;

  localparam int NUM_TA = 16;
  localparam int CNT_W  = 7;
  localparam int MAXV   = 127;

  logic              clk = 1'b0;
  logic              rst;
  logic              dec_off_i;
  logic              vec_valid_i;
  logic [1:0]        vec_type_i;
  logic              pkt_valid_i;
  logic [31:0]       pkt_data_i;
  logic [NUM_TA-1:0] ta_inc_i;
  logic              afm_o;
  logic [NUM_TA-1:0] ta_en_o;

  int errs   = 0;
  int checks = 0;
  int exp_ta[NUM_TA];
  int exp_af;
  bit exp_force;
  bit done = 0;

  always #5 clk = ~clk;

  afm_tracker #(.NUM_TA(NUM_TA), .CNT_W(CNT_W)) u_dut (
    .clk         (clk),
    .rst         (rst),
    .dec_off_i   (dec_off_i),
    .vec_valid_i (vec_valid_i),
    .vec_type_i  (vec_type_i),
    .pkt_valid_i (pkt_valid_i),
    .pkt_data_i  (pkt_data_i),
    .ta_inc_i    (ta_inc_i),
    .afm_o       (afm_o),
    .ta_en_o     (ta_en_o)
  );

  function automatic logic [31:0] ctl(input bit daf, input bit faf, input logic [15:0] mask);
    return {8'h03, daf, faf, 6'b0, mask};
  endfunction

  function automatic int sat(input int v, input bit up, input bit dn);
    if (up && !dn && v < MAXV) return v + 1;
    if (dn && !up && v > 0) return v - 1;
    return v;
  endfunction

  task automatic model(input bit vv, input logic [1:0] vt, input bit pv,
                       input logic [31:0] pd, input logic [15:0] inc, input bit off);
    bit hit;
    hit = pv && (pd[31:24] == 8'h03);
    if (off) begin
      exp_af = 0;
      exp_force = 0;
      for (int i = 0; i < NUM_TA; i++) exp_ta[i] = 0;
    end else begin
      exp_af = sat(exp_af, vv && (vt != 2'b00), hit && pd[23]);
      for (int i = 0; i < NUM_TA; i++) exp_ta[i] = sat(exp_ta[i], inc[i], hit && pd[i]);
      if (hit) exp_force = pd[22];
    end
  endtask

  task automatic compare(input string tag);
    logic [NUM_TA-1:0] een;
    logic              eafm;
    eafm = exp_force || (exp_af > 0);
    for (int i = 0; i < NUM_TA; i++) begin
      een[i] = (exp_ta[i] > 0);
      if (exp_ta[i] > 0) eafm = 1'b1;
    end
    checks++;
    if (afm_o !== eafm || ta_en_o !== een) begin
      errs++;
      $display("FAIL %s: afm_o=%0b ta_en_o=%h expected afm_o=%0b ta_en_o=%h",
               tag, afm_o, ta_en_o, eafm, een);
    end
  endtask

  task automatic idle_inputs();
    dec_off_i   = 1'b0;
    vec_valid_i = 1'b0;
    vec_type_i  = 2'b00;
    pkt_valid_i = 1'b0;
    pkt_data_i  = '0;
    ta_inc_i    = '0;
  endtask

  task automatic pulse(input bit vv, input logic [1:0] vt, input bit pv,
                       input logic [31:0] pd, input logic [15:0] inc, input bit off,
                       input string tag);
    vec_valid_i = vv;
    vec_type_i  = vt;
    pkt_valid_i = pv;
    pkt_data_i  = pd;
    ta_inc_i    = inc;
    dec_off_i   = off;
    model(vv, vt, pv, pd, inc, off);
    @(negedge clk);
    idle_inputs();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic vec(input logic [1:0] t, input string tag);
    pulse(1'b1, t, 1'b0, '0, '0, 1'b0, tag);
  endtask

  task automatic pkt(input logic [31:0] w, input string tag);
    pulse(1'b0, 2'b00, 1'b1, w, '0, 1'b0, tag);
  endtask

  task automatic inc(input logic [15:0] m, input string tag);
    pulse(1'b0, 2'b00, 1'b0, '0, m, 1'b0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: afm_o=%0b ta_en_o=%h expected run to finish", afm_o, ta_en_o);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    idle_inputs();
    exp_af = 0;
    exp_force = 0;
    for (int i = 0; i < NUM_TA; i++) exp_ta[i] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    compare("R3 reset state");

    // R1: each vector kind, plus the other kind that must not count
    vec(2'b00, "R1 other kind ignored");
    for (int t = 1; t < 4; t++) begin
      vec(2'(t), "R1 counted kind");
      pkt(ctl(1'b0, 1'b0, 16'h0000), "R5 DAF clear keeps counter");
      pkt(ctl(1'b1, 1'b0, 16'h0000), "R5 DAF lowers counter");
    end

    // R2: all-frame counter saturation at both ends
    for (int i = 0; i < 130; i++) vec(2'(i % 3 + 1), "R2 af fill");
    for (int i = 0; i < MAXV; i++) pkt(ctl(1'b1, 1'b0, 16'h0000), "R2 af drain");
    pkt(ctl(1'b1, 1'b0, 16'h0000), "R2 af floor");
    vec(2'b11, "R2 af step after floor");
    pkt(ctl(1'b1, 1'b0, 16'h0000), "R2 af back to zero");

    // R11: outputs lag the counters by one register
    ta_inc_i = 16'h0001;
    exp_ta[0] = 1;
    @(negedge clk);
    ta_inc_i = '0;
    checks++;
    if (ta_en_o[0] !== 1'b0) begin
      errs++;
      $display("FAIL R11 early output: ta_en_o[0]=%0b expected 0", ta_en_o[0]);
    end
    @(negedge clk);
    compare("R11 output after second edge");
    pkt(ctl(1'b0, 1'b0, 16'h0001), "R7 single bit lowers");

    // R7 R9: per-address sweep with distinct depths
    for (int i = 0; i < NUM_TA; i++)
      for (int k = 0; k <= i % 4; k++) inc(16'(1 << i), "R9 per-address raise");
    for (int m = 0; m < 4; m++) pkt(ctl(1'b0, 1'b0, 16'hFFFF), "R7 mask drains by depth");
    for (int i = 0; i < NUM_TA; i++) inc(16'(1 << i), "R9 walking enable");
    for (int i = 0; i < NUM_TA; i += 2) pkt(ctl(1'b0, 1'b0, 16'(1 << i)), "R7 even bits");
    pkt(ctl(1'b0, 1'b0, 16'hAAAA), "R7 odd bits");

    // R2: enable counters saturate in parallel
    for (int i = 0; i < 130; i++) inc(16'hFFFF, "R2 ta fill");
    for (int i = 0; i < MAXV; i++) pkt(ctl(1'b0, 1'b0, 16'hFFFF), "R2 ta drain");
    pkt(ctl(1'b0, 1'b0, 16'hFFFF), "R2 ta floor");

    // R4: every wrong identifier ignored, with all action bits set
    inc(16'h5A5A, "R4 preload");
    for (int id = 0; id < 256; id++)
      if (id != 3) pkt({8'(id), 2'b11, 6'b0, 16'hFFFF}, "R4 wrong identifier");
    pulse(1'b0, 2'b00, 1'b0, ctl(1'b1, 1'b1, 16'hFFFF), '0, 1'b0, "R4 word without strobe");

    // R6: force flag set, overwritten, reserved bits ignored
    pkt(ctl(1'b0, 1'b0, 16'h5A5A), "R7 clear preload");
    pkt(ctl(1'b0, 1'b1, 16'h0000), "R6 force on with zero counters");
    pkt({8'h03, 2'b00, 6'b111111, 16'h0000}, "R6 force off, reserved bits ignored");
    pkt(ctl(1'b0, 1'b1, 16'h0000), "R6 force on again");
    pulse(1'b0, 2'b00, 1'b0, '0, '0, 1'b1, "R3 off clears force");

    // R8: same-cycle increment and decrement cancel
    inc(16'h0010, "R8 preload");
    pulse(1'b0, 2'b00, 1'b1, ctl(1'b0, 1'b0, 16'h0010), 16'h0010, 1'b0, "R8 ta cancel keeps 1");
    pulse(1'b0, 2'b00, 1'b1, ctl(1'b0, 1'b0, 16'h0020), 16'h0020, 1'b0, "R8 ta cancel at zero");
    pkt(ctl(1'b0, 1'b0, 16'h0010), "R8 ta then lowers");
    vec(2'b10, "R8 af preload");
    pulse(1'b1, 2'b01, 1'b1, ctl(1'b1, 1'b0, 16'h0000), '0, 1'b0, "R8 af cancel");
    pkt(ctl(1'b1, 1'b0, 16'h0000), "R8 af then lowers");

    // R3: off clears everything and beats a pending increment
    for (int i = 0; i < 3; i++) vec(2'b01, "R3 af preload");
    inc(16'hC3C3, "R3 ta preload");
    pulse(1'b1, 2'b11, 1'b0, '0, 16'hFFFF, 1'b1, "R3 off priority");
    inc(16'h8001, "R10 ta only sets mode");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule